// File: doc/BRIEF.md
# Oversampled Serial Frame Receiver

This block turns an asynchronous, idle-high serial line into received words. A frame opens with one low start bit, followed by 8 or 9 bit positions sent least significant bit first, and closes with one stop bit. The receiver runs from a tick that arrives at sixteen times the bit rate. It takes three samples around the centre of every bit and uses the majority value. It reports the stored word together with a word-ready flag, a receiver-idle flag and four error flags: overrun, framing, parity and noise.

Two enables control the block. `unit_en` is the master enable. Dropping it abandons any frame in progress, discards the held word and clears every flag. `rcv_en` only stops the receiver from taking new frames; the held word and the flags are kept. The host acknowledges a word by pulsing `rd_ack`. When parity is enabled, the parity bit takes the top position of the 8- or 9-position frame and is stored in the word with the data bits. In 9-position mode without parity, the top bit is typically used by a higher layer as an address marker. This block only passes that bit out.

The state machine has four states:
- `S_IDLE` waits for a low line on a tick. That transition is the start detection.
- `S_START` validates the start bit. It returns to `S_IDLE` when the start-bit majority is high (false start), and moves to `S_DATA` at the end of the start bit.
- `S_DATA` stores one position per bit. It moves to `S_STOP` after the last position.
- `S_STOP` samples the stop bit, completes the frame and returns to `S_IDLE`.

Any state returns to `S_IDLE` when either enable is low.

Top module: `uart_frame_rx`

## Requirements
- R1: Bits arrive least significant first into `rx_word`. `wide_sel`=0 selects 8 positions and `wide_sel`=1 selects 9. `rx_word` bits above the selected count read 0.
- R2: Each bit is sampled on ticks 7, 8 and 9 of that bit, counting the start-detection tick as tick 0. The majority of the three samples is the bit value.
- R3: A start bit whose majority is high is a false start. The receiver returns to idle and neither `rx_ready` nor any flag changes.
- R4: Exactly one stop bit is sampled. A low stop-bit majority sets `err_frm` together with the stored word.
- R5: With `par_en`=1, the top selected position is the parity bit. The count of ones over all selected positions must be even when `par_odd`=0 and odd when `par_odd`=1. A mismatch sets `err_par`. With `par_en`=0, `err_par` stays 0.
- R6: If the three samples of any bit in a frame (start, data or stop) disagree, `err_noise` is set with that word. The majority value is still stored.
- R7: `rx_ready` rises one cycle after a frame completes and falls one cycle after an `rd_ack` pulse. If a frame completes in the same cycle as `rd_ack`, the new word is stored and `rx_ready` stays high.
- R8: If a frame completes while `rx_ready` is high and `rd_ack` is low, `err_ovr` is set, the new word is dropped, and the word and the other flags are left unchanged. `err_ovr` stays set until `unit_en` is lowered.
- R9: `rx_idle` is low from the cycle after start detection until the stop bit has been sampled, or until a false start is found. It is high otherwise.
- R10: `unit_en`=0 abandons any frame. On the next cycle `rx_word` reads 0, `rx_ready` and all error flags read 0, and `rx_idle` reads 1.
- R11: `rcv_en`=0 abandons any frame and ignores the line. It keeps `rx_word`, `rx_ready` and the error flags.
- R12: `err_frm`, `err_par` and `err_noise` describe the most recently stored word and are replaced by each stored frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| unit_en | input | 1 | Master enable; low clears the block |
| rcv_en | input | 1 | Receive enable |
| wide_sel | input | 1 | 0: 8 positions, 1: 9 positions |
| par_en | input | 1 | Parity check on the top position |
| par_odd | input | 1 | 0: even parity, 1: odd parity |
| rd_ack | input | 1 | Host has read `rx_word` |
| rx_line | input | 1 | Serial input, idle high |
| rx_word | output | 9 | Last stored word |
| rx_ready | output | 1 | Unread word held |
| rx_idle | output | 1 | No frame in progress |
| err_ovr | output | 1 | Frame dropped while a word was unread |
| err_frm | output | 1 | Stop bit sampled low |
| err_par | output | 1 | Parity mismatch |
| err_noise | output | 1 | Disagreeing samples in the frame |

## Verification
The assertions check several behaviours on every cycle:
- the master-enable clear;
- the overrun drop, which keeps the word;
- acknowledge clearing `rx_ready`;
- `rx_ready` rising only out of the stop state;
- the false-start return to idle;
- the idle flag falling after start detection.

Other behaviours can only be shown by the bench's scenarios, which place line edges at known tick phases:
- bit order and word masking in both widths;
- parity mismatches of both types;
- a low stop bit;
- a one-sample glitch that sets the noise flag but leaves the data unchanged;
- a frame ignored while `rcv_en` is low;
- a frame abandoned halfway by the master enable.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_START = 2'd1,
        S_DATA  = 2'd2,
        S_STOP  = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[g] <= 1'b1;
                end else if (g == 0) begin
                    chain[g] <= din;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_vote3.sv
module rx_vote3 #(
    parameter int CW    = 4,
    parameter int SMP_A = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] phase,
    input  logic          line,
    output logic          maj,
    output logic          dis
);
    localparam logic [CW-1:0] PH_A = CW'(SMP_A);
    localparam logic [CW-1:0] PH_B = CW'(SMP_A + 1);

    logic s0, s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s0 <= 1'b1;
            s1 <= 1'b1;
        end else if (tick) begin
            if (phase == PH_A) s0 <= line;
            if (phase == PH_B) s1 <= line;
        end
    end

    // third sample is the live line at the third phase
    assign maj = (s0 & s1) | (s0 & line) | (s1 & line);
    assign dis = !((s0 == s1) && (s1 == line));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int MAXW        = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            os_tick,
    input  logic            unit_en,
    input  logic            rcv_en,
    input  logic            wide_sel,
    input  logic            par_en,
    input  logic            par_odd,
    input  logic            rd_ack,
    input  logic            rx_line,
    output logic [MAXW-1:0] rx_word,
    output logic            rx_ready,
    output logic            rx_idle,
    output logic            err_ovr,
    output logic            err_frm,
    output logic            err_par,
    output logic            err_noise
);
    localparam int CW = $clog2(OSR);
    localparam int IW = $clog2(MAXW);
    localparam int SMP_A = OSR/2 - 1;
    localparam logic [CW-1:0] PH_LAST = CW'(SMP_A + 2);
    localparam logic [CW-1:0] PH_END  = CW'(OSR - 1);
    localparam logic [IW-1:0] IDX_WIDE = IW'(MAXW - 1);
    localparam logic [IW-1:0] IDX_NARROW = IW'(MAXW - 2);

    rx_state_e st, st_n;
    logic [CW-1:0] tcnt;
    logic [IW-1:0] bidx;
    logic [MAXW-1:0] shreg;
    logic noise_acc;
    logic line_s, maj, dis;
    logic run, smp_tk, end_tk, fin, detect;
    logic [IW-1:0] last_idx;

    rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
    );

    rx_vote3 #(.CW(CW), .SMP_A(SMP_A)) i_vote (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .phase(tcnt),
        .line(line_s), .maj(maj), .dis(dis)
    );

    assign run      = unit_en & rcv_en;
    assign smp_tk   = os_tick && (tcnt == PH_LAST);
    assign end_tk   = os_tick && (tcnt == PH_END);
    assign last_idx = wide_sel ? IDX_WIDE : IDX_NARROW;
    assign detect   = (st == S_IDLE) && run && os_tick && !line_s;
    assign fin      = (st == S_STOP) && smp_tk && run;

    // next-state decision
    always_comb begin
        st_n = st;
        unique case (st)
            S_IDLE:  if (detect) st_n = S_START;
            S_START: begin
                if (smp_tk && maj)  st_n = S_IDLE;
                else if (end_tk)    st_n = S_DATA;
            end
            S_DATA:  if (end_tk && (bidx == last_idx)) st_n = S_DATA == S_DATA ? S_STOP : S_DATA;
            S_STOP:  if (smp_tk) st_n = S_IDLE;
            default: st_n = S_IDLE;
        endcase
        if (!run) st_n = S_IDLE;
    end

    // state register and frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            tcnt      <= '0;
            bidx      <= '0;
            shreg     <= '0;
            noise_acc <= 1'b0;
        end else begin
            st <= st_n;
            if (st == S_IDLE) begin
                tcnt      <= CW'(1);
                bidx      <= '0;
                shreg     <= '0;
                noise_acc <= 1'b0;
            end else begin
                if (os_tick) tcnt <= tcnt + 1'b1;
                if (smp_tk) noise_acc <= noise_acc | dis;
                if (st == S_DATA) begin
                    if (smp_tk) shreg[bidx] <= maj;
                    if (end_tk) bidx <= bidx + 1'b1;
                end
            end
        end
    end

    // host-visible outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word   <= '0;
            rx_ready  <= 1'b0;
            err_ovr   <= 1'b0;
            err_frm   <= 1'b0;
            err_par   <= 1'b0;
            err_noise <= 1'b0;
        end else if (!unit_en) begin
            rx_word   <= '0;
            rx_ready  <= 1'b0;
            err_ovr   <= 1'b0;
            err_frm   <= 1'b0;
            err_par   <= 1'b0;
            err_noise <= 1'b0;
        end else if (fin) begin
            if (rx_ready && !rd_ack) begin
                err_ovr <= 1'b1;
            end else begin
                rx_word   <= shreg;
                rx_ready  <= 1'b1;
                err_frm   <= !maj;
                err_par   <= par_en && ((^shreg) != par_odd);
                err_noise <= noise_acc | dis;
            end
        end else if (rd_ack) begin
            rx_ready <= 1'b0;
        end
    end

    assign rx_idle = (st == S_IDLE);

    p_off_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !unit_en |=> (rx_idle && !rx_ready && !err_ovr && !err_frm && !err_par && !err_noise && rx_word == '0));

    p_ovr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && rx_ready && !rd_ack) |=> (err_ovr && $stable(rx_word) && rx_ready));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !fin && unit_en) |=> !rx_ready);

    p_ready_from_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> ($past(st) == S_STOP));

    p_false_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_START && smp_tk && maj) |=> (rx_idle && $stable(rx_ready)));

    p_idle_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        detect |=> !rx_idle);
endmodule

// File: tb/test_uart_frame_rx.sv
module test_uart_frame_rx;
    logic clk = 0, rst_n = 0, os_tick = 0;
    logic unit_en = 0, rcv_en = 0, wide_sel = 0, par_en = 0, par_odd = 0;
    logic rd_ack = 0, rx_line = 1;
    logic [8:0] rx_word;
    logic rx_ready, rx_idle, err_ovr, err_frm, err_par, err_noise;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    uart_frame_rx i_uart_frame_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .unit_en(unit_en),
        .rcv_en(rcv_en), .wide_sel(wide_sel), .par_en(par_en), .par_odd(par_odd),
        .rd_ack(rd_ack), .rx_line(rx_line), .rx_word(rx_word), .rx_ready(rx_ready),
        .rx_idle(rx_idle), .err_ovr(err_ovr), .err_frm(err_frm), .err_par(err_par),
        .err_noise(err_noise)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            repeat (3) begin @(negedge clk); os_tick = 0; end
            @(negedge clk); os_tick = 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_word(input logic [8:0] d, input int n);
        return (n == 9) ? d : {1'b0, d[7:0]};
    endfunction

    function automatic logic exp_perr(input logic [8:0] w, input logic pe, input logic po);
        return pe && ((^w) != po);
    endfunction

    task automatic drive_bit(input logic v, input bit glitch);
        rx_line = v;
        if (glitch) begin
            repeat (33) @(negedge clk);
            rx_line = !v;
            @(negedge clk);
            rx_line = v;
            repeat (30) @(negedge clk);
        end else begin
            repeat (64) @(negedge clk);
        end
    endtask

    task automatic align();
        do @(posedge clk); while (os_tick !== 1'b1);
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input int n, input logic stopv, input int gbit);
        align();
        drive_bit(1'b0, gbit == 0);
        for (int i = 0; i < n; i++) drive_bit(d[i], gbit == i + 1);
        drive_bit(stopv, gbit == n + 1);
        rx_line = 1;
        repeat (128) @(negedge clk);
    endtask

    task automatic ack();
        @(negedge clk); rd_ack = 1;
        @(negedge clk); rd_ack = 0;
        @(negedge clk);
    endtask

    task automatic set_fmt(input logic w, input logic pe, input logic po);
        @(negedge clk);
        wide_sel = w; par_en = pe; par_odd = po;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state (R10 shape)
        chk("R10 reset idle", rx_idle, 1);
        chk("R10 reset ready", rx_ready, 0);
        chk("R10 reset flags", {err_ovr, err_frm, err_par, err_noise}, 0);
        unit_en = 1; rcv_en = 1;
        repeat (8) @(negedge clk);

        // R1 8-position, lsb first
        set_fmt(0, 0, 0);
        send_frame(9'h0A5, 8, 1, -1);
        chk("R1 word 8", rx_word, 9'h0A5);
        chk("R7 ready set", rx_ready, 1);
        chk("R12 flags clean", {err_frm, err_par, err_noise}, 0);
        ack();
        chk("R7 ready cleared by ack", rx_ready, 0);

        // R1 9-position
        set_fmt(1, 0, 0);
        send_frame(9'h1C3, 9, 1, -1);
        chk("R1 word 9", rx_word, 9'h1C3);
        ack();
        // R1 high bit masked in 8 mode
        set_fmt(0, 0, 0);
        send_frame(9'h1FF, 8, 1, -1);
        chk("R1 masked top", rx_word, 9'h0FF);
        ack();

        // R5 parity even, correct then wrong
        set_fmt(0, 1, 0);
        send_frame(9'h003, 8, 1, -1);
        chk("R5 even ok", err_par, 0);
        ack();
        send_frame(9'h083, 8, 1, -1);
        chk("R5 even bad", err_par, 1);
        chk("R5 word keeps parity bit", rx_word, 9'h083);
        ack();
        set_fmt(1, 1, 1);
        send_frame(9'h001, 9, 1, -1);
        chk("R5 odd ok", err_par, 0);
        ack();
        send_frame(9'h101, 9, 1, -1);
        chk("R5 odd bad", err_par, 1);
        ack();

        // R4 low stop bit
        set_fmt(0, 0, 0);
        send_frame(9'h05A, 8, 0, -1);
        chk("R4 framing", err_frm, 1);
        chk("R4 word", rx_word, 9'h05A);
        ack();
        // R12 next clean frame replaces flags
        send_frame(9'h011, 8, 1, -1);
        chk("R12 framing replaced", err_frm, 0);
        ack();

        // R6 / R2 single sample glitch in data bit 3
        send_frame(9'h0F0, 8, 1, 4);
        chk("R6 noise set", err_noise, 1);
        chk("R2 majority kept data", rx_word, 9'h0F0);
        ack();

        // R3 / R9 false start
        align();
        rx_line = 0;
        repeat (12) @(negedge clk);
        chk("R9 idle low after detect", rx_idle, 0);
        rx_line = 1;
        repeat (60) @(negedge clk);
        chk("R3 false start idle", rx_idle, 1);
        chk("R3 no ready", rx_ready, 0);
        chk("R3 flags unchanged", {err_frm, err_noise}, 2'b01);

        // R8 overrun
        send_frame(9'h033, 8, 1, -1);
        send_frame(9'h0CC, 8, 0, -1);
        chk("R8 overrun flag", err_ovr, 1);
        chk("R8 word kept", rx_word, 9'h033);
        chk("R8 framing untouched", err_frm, 0);
        ack();
        send_frame(9'h044, 8, 1, -1);
        chk("R8 overrun sticky", err_ovr, 1);
        ack();

        // R10 clear, R11 receive disabled
        @(negedge clk); unit_en = 0;
        @(negedge clk); @(negedge clk);
        chk("R10 cleared", {rx_word, rx_ready, err_ovr, err_frm, err_par, err_noise}, 0);
        unit_en = 1;
        send_frame(9'h066, 8, 1, -1);
        chk("R10 re-enabled word", rx_word, 9'h066);
        @(negedge clk); rcv_en = 0;
        send_frame(9'h099, 8, 1, -1);
        chk("R11 word kept", rx_word, 9'h066);
        chk("R11 ready kept", rx_ready, 1);
        chk("R11 idle", rx_idle, 1);
        @(negedge clk); rcv_en = 1;
        ack();

        // R10 abandon mid-frame
        align();
        drive_bit(0, 0); drive_bit(1, 0); drive_bit(0, 0);
        chk("R9 busy mid-frame", rx_idle, 0);
        unit_en = 0;
        @(negedge clk); @(negedge clk);
        chk("R10 mid-frame idle", rx_idle, 1);
        rx_line = 1;
        repeat (700) @(negedge clk);
        unit_en = 1;
        chk("R10 no partial word", rx_ready, 0);

        // random frames
        for (int k = 0; k < 40; k++) begin
            logic w, pe, po, stp;
            logic [8:0] d, ew;
            int n;
            w = 1'($urandom); pe = 1'($urandom); po = 1'($urandom);
            stp = ($urandom % 10) != 0;
            n = w ? 9 : 8;
            d = 9'($urandom);
            if (pe && ($urandom % 4) != 0) d[n-1] = (^(exp_word(d, n) & ~(9'(1) << (n-1)))) ^ po;
            set_fmt(w, pe, po);
            send_frame(d, n, stp, -1);
            ew = exp_word(d, n);
            chk("R1 random word", rx_word, ew);
            chk("R5 random parity", err_par, exp_perr(ew, pe, po));
            chk("R4 random framing", err_frm, !stp);
            chk("R6 random noise", err_noise, 0);
            ack();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule